// File: doc/BRIEF.md
# Station Address Search Engine

The engine looks up a 48-bit station address in a table of stored addresses and reports whether it found it and at which index. Entries are written into an internal table through a dedicated load port. Software reaches the engine through a small 16-bit register window.

To run a lookup, software writes the key as three 16-bit words and writes the number of valid entries. It then writes a 1 to the start bit of the control register and polls that register. The engine tests one table entry per clock, lowest index first, and stops at the first hit.

When the start bit reads back as zero, the control register holds the outcome. One bit says whether a hit was found. A 6-bit field holds the index of the hit.

Register map (select on `reg_addr_i`):
- 0: control / status
- 1: valid-entry count
- 2: key bits 47:32
- 3: key bits 31:16
- 4: key bits 15:0

Selects 5 to 7 read as zero and ignore writes.

Top module: `tam_search`

## Requirements
- R1: After reset the control register reads 0x0000, so the engine is idle, with no hit and index 0.
- R2: Writing the control register with bit 0 set while idle starts a search. From the next cycle, bit 0 reads 1, bit 1 (hit) reads 0 and bits 7:2 (index) read 0.
- R3: Bit 0 stays set while entries are being tested. One entry is tested per clock, in ascending index order. Bit 0 clears after k+1 busy cycles on a hit at index k, and after N busy cycles on a miss, where N is the effective count.
- R4: On completion with a hit, bit 1 reads 1 and bits 7:2 hold the lowest index whose entry equals the key.
- R5: On completion with no hit among the first N entries, bits 1 and 7:2 read 0.
- R6: A count of zero completes after exactly one busy cycle, reporting no hit.
- R7: A count larger than the table depth (64) is treated as the depth.
- R8: Writes to the key or count registers while a search is running do not change that search's result or duration.
- R9: The key words and the count read back the last value written. Entries written through the load port are the values searched.
- R10: Writing the control register while a search is running neither restarts nor stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected register, combinational |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_addr_i | input | 6 | Table entry index |
| tbl_wdata_i | input | 48 | Table entry address value |

## Verification
The assertions rely on two conditions that the bench keeps:
- Every table entry inside the effective count has been loaded before a search starts.
- The load port is quiet while a search runs.

The bench fills all 64 entries before any search and drives the load port only between searches. The bench does drive register writes in the middle of a search, because R8 and R10 require it. Random keys come either from stored entries or from fresh values, and random counts range past the depth. Together these reach hits, misses, the zero count and clamping.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned KEY_W  = 48;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned FIELD_W = 6;  // index field, ctrl bits 7:2

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_KEY_H = 3'd2,
    SEL_KEY_M = 3'd3,
    SEL_KEY_L = 3'd4
  } tam_sel_e;
endpackage

// File: rtl/tam_table.sv
module tam_table #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned KEY_W = 48,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [KEY_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [KEY_W-1:0] rdata_o
);
  logic [KEY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tam_walker.sv
module tam_walker #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned KEY_W = 48,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LIM_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [KEY_W-1:0] rd_entry_i,
  output logic             busy_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [LIM_W-1:0] DEPTH_L = LIM_W'(DEPTH);

  logic [KEY_W-1:0] key_q;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic [IDX_W-1:0] cur_q;
  logic             busy_q, hit_q;
  logic [IDX_W-1:0] res_q;
  logic             is_last;

  // clamp the requested count to the table depth
  assign lim_d   = (count_i > CNT_W'(DEPTH)) ? DEPTH_L : count_i[LIM_W-1:0];
  assign is_last = ({1'b0, cur_q} == lim_q - LIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      lim_q  <= '0;
      cur_q  <= '0;
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
      res_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        key_q  <= key_i;
        lim_q  <= lim_d;
        cur_q  <= '0;
        busy_q <= 1'b1;
        hit_q  <= 1'b0;
        res_q  <= '0;
      end
    end else if (lim_q == '0) begin
      busy_q <= 1'b0;
    end else if (rd_entry_i == key_q) begin
      busy_q <= 1'b0;
      hit_q  <= 1'b1;
      res_q  <= cur_q;
    end else if (is_last) begin
      busy_q <= 1'b0;
    end else begin
      cur_q <= cur_q + IDX_W'(1);
    end
  end

  assign rd_idx_o = cur_q;
  assign busy_o   = busy_q;
  assign hit_o    = hit_q;
  assign idx_o    = res_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && !hit_q && res_q == '0));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (cur_q == $past(cur_q) + IDX_W'(1)));
  p_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && lim_q != '0) |-> ({1'b0, cur_q} < lim_q));
  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q <= DEPTH_L);
  p_key_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(key_q) && $stable(lim_q)));
  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && lim_q == '0) |=> (!busy_q && !hit_q));
  p_hit_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> !busy_q);
endmodule

// File: rtl/tam_regs.sv
module tam_regs #(
  parameter int unsigned IDX_W = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [tam_pkg::SEL_W-1:0]      addr_i,
  input  logic [tam_pkg::WORD_W-1:0]     wdata_i,
  output logic [tam_pkg::WORD_W-1:0]     rdata_o,
  output logic                           start_o,
  output logic [tam_pkg::KEY_W-1:0]      key_o,
  output logic [tam_pkg::WORD_W-1:0]     count_o,
  input  logic                           busy_i,
  input  logic                           hit_i,
  input  logic [IDX_W-1:0]               idx_i
);
  import tam_pkg::*;

  logic [WORD_W-1:0] key_h_q, key_m_q, key_l_q, count_q;
  logic [WORD_W-1:0] status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_h_q <= '0;
      key_m_q <= '0;
      key_l_q <= '0;
      count_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        SEL_COUNT: count_q <= wdata_i;
        SEL_KEY_H: key_h_q <= wdata_i;
        SEL_KEY_M: key_m_q <= wdata_i;
        SEL_KEY_L: key_l_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign start_o = we_i && (addr_i == SEL_CTRL) && wdata_i[0];
  assign key_o   = {key_h_q, key_m_q, key_l_q};
  assign count_o = count_q;

  assign status = {{(WORD_W-FIELD_W-2){1'b0}}, FIELD_W'(idx_i), hit_i, busy_i};

  always_comb begin
    unique case (addr_i)
      SEL_CTRL:  rdata_o = status;
      SEL_COUNT: rdata_o = count_q;
      SEL_KEY_H: rdata_o = key_h_q;
      SEL_KEY_M: rdata_o = key_m_q;
      SEL_KEY_L: rdata_o = key_l_q;
      default:   rdata_o = '0;
    endcase
  end

  p_count_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_COUNT) |=> (count_q == $past(wdata_i)));
endmodule

// File: rtl/tam_search.sv
module tam_search #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [2:0]                 reg_addr_i,
  input  logic [15:0]                reg_wdata_i,
  output logic [15:0]                reg_rdata_o,
  input  logic                       tbl_we_i,
  input  logic [IDX_W-1:0]           tbl_addr_i,
  input  logic [47:0]                tbl_wdata_i
);
  import tam_pkg::*;

  logic              start;
  logic [KEY_W-1:0]  key;
  logic [WORD_W-1:0] count;
  logic [IDX_W-1:0]  rd_idx;
  logic [KEY_W-1:0]  rd_entry;
  logic              busy, hit;
  logic [IDX_W-1:0]  res_idx;

  tam_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .start_o (start),
    .key_o   (key),
    .count_o (count),
    .busy_i  (busy),
    .hit_i   (hit),
    .idx_i   (res_idx)
  );

  tam_table #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .raddr_i (rd_idx),
    .rdata_o (rd_entry)
  );

  tam_walker #(.DEPTH(DEPTH), .KEY_W(KEY_W), .CNT_W(WORD_W)) u_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .key_i      (key),
    .count_i    (count),
    .rd_idx_o   (rd_idx),
    .rd_entry_i (rd_entry),
    .busy_o     (busy),
    .hit_o      (hit),
    .idx_o      (res_idx)
  );

  p_restart_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start) |=> (rd_idx != '0 || !busy));
  p_done_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && !hit) |-> (res_idx == '0));
endmodule

// File: tb/tam_search_bench.sv
module tam_search_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = 6'd0;
  logic [47:0] tbl_wdata = 48'd0;

  logic [47:0] model [DEPTH];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tam_search u_tam_search (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic load(input int i, input logic [47:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(i); tbl_wdata = v;
    model[i] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_key(input logic [47:0] k);
    wr(3'd2, k[47:32]); wr(3'd3, k[31:16]); wr(3'd4, k[15:0]);
  endtask

  // expected {hit, index, busy cycles}
  function automatic void expect_of(input logic [47:0] k, input int cnt,
                                    output int hit, output int idx, output int cyc);
    int lim;
    lim = (cnt > DEPTH) ? DEPTH : cnt;
    hit = 0; idx = 0; cyc = (lim == 0) ? 1 : lim;
    for (int i = 0; i < lim; i++) begin
      if (model[i] == k) begin
        hit = 1; idx = i; cyc = i + 1;
        return;
      end
    end
  endfunction

  // mode 0: plain, 1: rewrite key/count mid-search, 2: rewrite ctrl mid-search
  task automatic search(input string req, input logic [47:0] k, input int cnt, input int mode);
    int eh, ei, ec, cyc;
    logic [15:0] st;
    logic [47:0] alt;
    expect_of(k, cnt, eh, ei, ec);
    set_key(k);
    wr(3'd1, 16'(cnt));
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0001;
    cyc = 0;
    alt = model[0];
    forever begin
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 3'd0;
      #1 st = reg_rdata;
      if (!st[0]) break;
      if (cyc == 0) check({req, " R2 start clears"}, int'(st[7:1]), 0);
      cyc++;
      if (cyc > 200) break;
      if (mode == 1 && cyc >= 2 && cyc <= 5) begin
        reg_we = 1'b1;
        case (cyc)
          2: begin reg_addr = 3'd2; reg_wdata = alt[47:32]; end
          3: begin reg_addr = 3'd3; reg_wdata = alt[31:16]; end
          4: begin reg_addr = 3'd4; reg_wdata = alt[15:0]; end
          default: begin reg_addr = 3'd1; reg_wdata = 16'd1; end
        endcase
        #1 reg_we = 1'b1;
      end
      if (mode == 2 && cyc == 2) begin
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0001;
      end
    end
    check({req, " R4/R5 hit"}, int'(st[1]), eh);
    check({req, " R4/R5 index"}, int'(st[7:2]), ei);
    check({req, " R3 busy cycles"}, cyc, ec);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [47:0] k;
    int cnt;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, v);
    check("R1 ctrl after reset", int'(v), 0);

    for (int i = 0; i < DEPTH; i++)
      load(i, {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFE);
    load(40, model[10]);  // duplicate: lowest index must win
    load(63, 48'h0123_4567_89AB);

    // R9 readback
    set_key(48'hA1B2_C3D4_E5F6);
    wr(3'd1, 16'd77);
    rd(3'd2, v); check("R9 key high", int'(v), 16'hA1B2);
    rd(3'd3, v); check("R9 key mid",  int'(v), 16'hC3D4);
    rd(3'd4, v); check("R9 key low",  int'(v), 16'hE5F6);
    rd(3'd1, v); check("R9 count",    int'(v), 77);
    rd(3'd6, v); check("R9 unused select", int'(v), 0);

    search("R4 first entry", model[0], 64, 0);
    search("R4 duplicate lowest", model[10], 64, 0);
    search("R4 last entry", model[63], 64, 0);
    search("R5 miss full", 48'h0000_0000_0001, 64, 0);
    search("R5 beyond count", model[20], 20, 0);
    search("R4 at count edge", model[19], 20, 0);
    search("R6 zero count", model[0], 0, 0);
    search("R7 clamp", model[63], 500, 0);
    search("R7 clamp miss", 48'h0000_0000_0003, 16'hFFFF, 0);
    search("R8 mid writes", 48'h0000_0000_0005, 64, 1);
    rd(3'd1, v); check("R8/R9 count stored", int'(v), 1);
    rd(3'd2, v); check("R8/R9 key stored", int'(v), int'(model[0][47:32]));
    search("R10 ctrl mid write", model[30], 64, 2);
    search("R10 ctrl mid miss", 48'h0000_0000_0007, 40, 2);
    load(5, 48'hDEAD_BEEF_0000);
    search("R9 reload entry", 48'hDEAD_BEEF_0000, 64, 0);

    for (int n = 0; n < 40; n++) begin
      cnt = int'($urandom_range(0, 80));
      if ($urandom_range(0, 1) == 1) k = model[$urandom_range(0, DEPTH - 1)];
      else k = {$urandom(), $urandom()} | 48'h1;
      search("random", k, cnt, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule